// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits inside a processor core and gathers 32 level-sensitive interrupt request lines. Each line has its own mask bit and its own priority bit. The priority bit places the line at the low level or at the high level. The block also holds a global enable flag and an "in service" flag for each of the two levels. Every cycle it decides whether a request may be handed to the core. When one may, it gives a one-cycle take pulse with the winning line number and its level, and it marks that level as in service.

A high-level request may interrupt a low-level handler. A low-level request is held off while either level is in service, because a second low-level entry would overwrite the saved low-level context. The core ends a handler with a return strobe, which clears the in-service flag of the innermost level. Software reaches the mask, priority and flag registers through a small register port: writes take one cycle and reads are combinational. Line 3 is the timer. Lines 0 to 2 are reserved and can never be taken.

Top module: `irqc_top`

## Requirements
- R1: After reset, the mask register, the priority register, both global enables and both in-service flags all read as zero, and `irq_take` is low.
- R2: A line whose mask bit is clear is never taken, whatever its input does.
- R3: Lines 0, 1 and 2 are never taken. Their mask and priority bits always read 0, and writes to those bits are ignored.
- R4: Requests are level-sensitive. A take at a clock edge needs the line to be high in the cycle before that edge, and no request is latched once the line drops.
- R5: A set priority bit puts the line at the high level. A take of that line drives `irq_hi`=1. A clear bit gives `irq_hi`=0.
- R6: Among eligible lines of one level, the lowest-numbered line wins. An eligible high-level line always wins over any low-level line.
- R7: A low-level take needs both in-service flags clear. A high-level take needs only the high in-service flag clear, so it can preempt a low-level handler.
- R8: High-level takes need global enable bit 1 (E2), and low-level takes need global enable bit 0 (E1).
- R9: A take sets the in-service flag of its level in the same edge that raises `irq_take` for one cycle with `irq_id` equal to the line number.
- R10: A `rti_strobe` pulse clears the high in-service flag if it is set, and otherwise clears the low one.
- R11: Register map by `reg_addr`: 0 is the mask, 1 is the priority, 2 is the status (bit0 E1 and bit1 E2, both writable; bit2 low in-service and bit3 high in-service, both read-only), and 3 reads zero. A write is visible to reads and to arbitration from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| rti_strobe | input | 1 | Return-from-interrupt pulse from the core |
| irq_take | output | 1 | One-cycle pulse: a request was accepted |
| irq_id | output | 5 | Line number of the last accepted request |
| irq_hi | output | 1 | Level of the last accepted request (1 = high) |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values once reset is released. They also assume that `rti_strobe` is a single-cycle pulse standing for the return of a handler that was taken. The bench drives every input just after the falling edge and keeps each return strobe to one cycle. It issues return strobes only to unwind taken handlers, or to clear flags that are already idle, which the block treats as having no effect. With these inputs, the checks on nesting and on the in-service flags compare like with like.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int NUM_LINES = 32;
    parameter int RSVD_LINES = 3;
    parameter int ADDR_W = 2;
    localparam int ID_W = $clog2(NUM_LINES);
    localparam logic [NUM_LINES-1:0] RSVD_MASK =
        {{(NUM_LINES-RSVD_LINES){1'b0}}, {RSVD_LINES{1'b1}}};

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK = 2'd0,
        SEL_PRIO = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] prio;
        logic                 en_lo;
        logic                 en_hi;
        logic                 act_lo;
        logic                 act_hi;
        logic                 take;
        logic [ID_W-1:0]      id;
        logic                 hi;
    } ctl_t;
endpackage

// File: rtl/irqc_qualify.sv
module irqc_qualify #(
    parameter int N = 32,
    parameter int RSVD = 3
) (
    input  logic [N-1:0] lines,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] prio,
    output logic [N-1:0] cand_lo,
    output logic [N-1:0] cand_hi
);
    for (genvar g = 0; g < N; g++) begin : g_line
        if (g < RSVD) begin : g_rsvd
            assign cand_lo[g] = 1'b0;
            assign cand_hi[g] = 1'b0;
        end else begin : g_live
            assign cand_lo[g] = lines[g] & mask[g] & ~prio[g];
            assign cand_hi[g] = lines[g] & mask[g] & prio[g];
        end
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int N = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    input  logic                 rti_strobe,
    output logic                 irq_take,
    output logic [ID_W-1:0]      irq_id,
    output logic                 irq_hi
);
    ctl_t s_d, s_q;

    logic [NUM_LINES-1:0] cand_lo, cand_hi;
    logic                 found_lo, found_hi;
    logic [ID_W-1:0]      idx_lo, idx_hi;
    logic                 grant_lo, grant_hi;

    logic [NUM_LINES-1:0] mask_q, prio_q;
    logic                 en_lo_q, en_hi_q, act_lo_q, act_hi_q;

    assign mask_q   = s_q.mask;
    assign prio_q   = s_q.prio;
    assign en_lo_q  = s_q.en_lo;
    assign en_hi_q  = s_q.en_hi;
    assign act_lo_q = s_q.act_lo;
    assign act_hi_q = s_q.act_hi;

    irqc_qualify #(.N(NUM_LINES), .RSVD(RSVD_LINES)) u_qualify (
        .lines   (irq_in),
        .mask    (mask_q),
        .prio    (prio_q),
        .cand_lo (cand_lo),
        .cand_hi (cand_hi)
    );

    irqc_pick #(.N(NUM_LINES), .IW(ID_W)) u_pick_lo (
        .req   (cand_lo),
        .found (found_lo),
        .idx   (idx_lo)
    );

    irqc_pick #(.N(NUM_LINES), .IW(ID_W)) u_pick_hi (
        .req   (cand_hi),
        .found (found_hi),
        .idx   (idx_hi)
    );

    assign grant_hi = found_hi & en_hi_q & ~act_hi_q;
    assign grant_lo = found_lo & en_lo_q & ~act_lo_q & ~act_hi_q;

    always_comb begin
        s_d      = s_q;
        s_d.take = 1'b0;

        if (reg_wr) begin
            unique case (reg_sel_e'(reg_addr))
                SEL_MASK: s_d.mask = reg_wdata & ~RSVD_MASK;
                SEL_PRIO: s_d.prio = reg_wdata & ~RSVD_MASK;
                SEL_STAT: begin
                    s_d.en_lo = reg_wdata[0];
                    s_d.en_hi = reg_wdata[1];
                end
                default: ;
            endcase
        end

        if (rti_strobe) begin
            if (s_q.act_hi) s_d.act_hi = 1'b0;
            else            s_d.act_lo = 1'b0;
        end

        if (grant_hi) begin
            s_d.act_hi = 1'b1;
            s_d.take   = 1'b1;
            s_d.id     = idx_hi;
            s_d.hi     = 1'b1;
        end else if (grant_lo) begin
            s_d.act_lo = 1'b1;
            s_d.take   = 1'b1;
            s_d.id     = idx_lo;
            s_d.hi     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            SEL_MASK: reg_rdata = mask_q;
            SEL_PRIO: reg_rdata = prio_q;
            SEL_STAT: reg_rdata = {{(NUM_LINES-4){1'b0}}, act_hi_q, act_lo_q, en_hi_q, en_lo_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_take = s_q.take;
    assign irq_id   = s_q.id;
    assign irq_hi   = s_q.hi;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 rti_strobe,
    input logic                 irq_take,
    input logic [ID_W-1:0]      irq_id,
    input logic                 irq_hi,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] prio_q,
    input logic                 en_lo_q,
    input logic                 en_hi_q,
    input logic                 act_lo_q,
    input logic                 act_hi_q
);
    logic [NUM_LINES-1:0] prev_elig, prev_prio;

    always_ff @(posedge clk) begin
        prev_elig <= irq_in & mask_q;
        prev_prio <= prio_q;
    end

    assert_take_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> prev_elig[irq_id]);

    assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (int'(irq_id) >= RSVD_LINES));

    assert_level_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (prev_prio[irq_id] == irq_hi));

    assert_lo_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !irq_hi) |-> (!$past(act_lo_q) && !$past(act_hi_q)));

    assert_hi_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_hi) |-> !$past(act_hi_q));

    assert_hi_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_hi) |-> $past(en_hi_q));

    assert_lo_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !irq_hi) |-> $past(en_lo_q));

    assert_take_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_hi ? act_hi_q : act_lo_q));

    assert_rti_inner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_strobe && act_hi_q) |=> (!act_hi_q && $stable(act_lo_q)));
endmodule

bind irqc_top irqc_checker u_irqc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .rti_strobe (rti_strobe),
    .irq_take   (irq_take),
    .irq_id     (irq_id),
    .irq_hi     (irq_hi),
    .mask_q     (mask_q),
    .prio_q     (prio_q),
    .en_lo_q    (en_lo_q),
    .en_hi_q    (en_hi_q),
    .act_lo_q   (act_lo_q),
    .act_hi_q   (act_hi_q)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        rti_strobe;
    logic        irq_take;
    logic [4:0]  irq_id;
    logic        irq_hi;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    irqc_top u_irqc_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rti_strobe (rti_strobe),
        .irq_take   (irq_take),
        .irq_id     (irq_id),
        .irq_hi     (irq_hi)
    );

    // {req tag, mask, prio, {E2,E1}, lines, take, id, hi}
    localparam int NV = 12;
    localparam logic [108:0] VECS [NV] = '{
        {4'd6,  32'hFFFFFFFF, 32'h00000000, 2'b11, 32'h00000030, 1'b1, 5'd4,  1'b0}, // R6
        {4'd3,  32'hFFFFFFFF, 32'h00000000, 2'b11, 32'h00000007, 1'b0, 5'd0,  1'b0}, // R3
        {4'd2,  32'hFFFFFFEF, 32'h00000000, 2'b11, 32'h00000030, 1'b1, 5'd5,  1'b0}, // R2
        {4'd5,  32'hFFFFFFFF, 32'h80000000, 2'b11, 32'h80000010, 1'b1, 5'd31, 1'b1}, // R5
        {4'd8,  32'hFFFFFFFF, 32'h80000000, 2'b01, 32'h80000010, 1'b1, 5'd4,  1'b0}, // R8
        {4'd8,  32'hFFFFFFFF, 32'h00000000, 2'b00, 32'h00000010, 1'b0, 5'd0,  1'b0}, // R8
        {4'd8,  32'hFFFFFFFF, 32'h00000000, 2'b10, 32'h00000010, 1'b0, 5'd0,  1'b0}, // R8
        {4'd2,  32'h00000000, 32'h00000000, 2'b11, 32'hFFFFFFFF, 1'b0, 5'd0,  1'b0}, // R2
        {4'd6,  32'hFFFFFFFF, 32'hFFFFFFF0, 2'b11, 32'h00000018, 1'b1, 5'd4,  1'b1}, // R6
        {4'd5,  32'hFFFFFFFF, 32'h00000008, 2'b11, 32'h00000008, 1'b1, 5'd3,  1'b1}, // R5
        {4'd9,  32'hFFFFFFFF, 32'h00000000, 2'b11, 32'hFFFFFFFF, 1'b1, 5'd3,  1'b0}, // R9
        {4'd8,  32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10, 32'h00010000, 1'b1, 5'd16, 1'b1}  // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rti_pulse();
        rti_strobe = 1'b1;
        @(negedge clk);
        rti_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0;
        reg_wdata = '0; rti_strobe = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 take", {31'd0, irq_take}, 32'd0);
        reg_read(2'd0, rd); chk("R1 mask", rd, 32'd0);
        reg_read(2'd1, rd); chk("R1 prio", rd, 32'd0);
        reg_read(2'd2, rd); chk("R1 status", rd, 32'd0);

        // R3 and R11: reserved bits hardwired, unused address reads zero
        @(negedge clk);
        reg_write(2'd0, 32'hFFFFFFFF);
        reg_read(2'd0, rd); chk("R3 mask readback", rd, 32'hFFFFFFF8);
        reg_write(2'd1, 32'h00000007);
        reg_read(2'd1, rd); chk("R3 prio readback", rd, 32'd0);
        reg_read(2'd3, rd); chk("R11 unused addr", rd, 32'd0);
        reg_write(2'd2, 32'h0000000F);
        reg_read(2'd2, rd); chk("R11 status write", rd, 32'h00000003);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            irq_in = '0;
            rti_pulse();
            rti_pulse();
            reg_write(2'd0, VECS[v][104:73]);
            reg_write(2'd1, VECS[v][72:41]);
            reg_write(2'd2, {30'd0, VECS[v][40:39]});
            irq_in = VECS[v][38:7];
            @(negedge clk);
            chk($sformatf("R%0d vec%0d take", VECS[v][108:105], v), {31'd0, irq_take}, {31'd0, VECS[v][6]});
            if (VECS[v][6]) begin
                chk($sformatf("R%0d vec%0d id", VECS[v][108:105], v), {27'd0, irq_id}, {27'd0, VECS[v][5:1]});
                chk($sformatf("R%0d vec%0d level", VECS[v][108:105], v), {31'd0, irq_hi}, {31'd0, VECS[v][0]});
            end
            irq_in = '0;
        end

        // R4: nothing pending with lines low, one-cycle pulse taken once
        rti_pulse(); rti_pulse();
        reg_write(2'd0, 32'hFFFFFFF8);
        reg_write(2'd1, 32'h0);
        reg_write(2'd2, 32'h3);
        @(negedge clk);
        chk("R4 idle", {31'd0, irq_take}, 32'd0);
        irq_in = 32'h00000100;
        @(negedge clk);
        irq_in = '0;
        chk("R4 pulse taken", {31'd0, irq_take}, 32'd1);
        chk("R4 pulse id", {27'd0, irq_id}, 32'd8);
        rti_pulse();
        @(negedge clk);
        chk("R4 no latch after drop", {31'd0, irq_take}, 32'd0);

        // R11: write reaches arbitration one cycle after the write edge
        reg_write(2'd0, 32'h0);
        irq_in = 32'h00000200;
        @(negedge clk);
        chk("R11 masked", {31'd0, irq_take}, 32'd0);
        reg_write(2'd0, 32'h00000200);
        chk("R11 not same edge", {31'd0, irq_take}, 32'd0);
        @(negedge clk);
        chk("R11 next cycle take", {31'd0, irq_take}, 32'd1);
        chk("R11 id", {27'd0, irq_id}, 32'd9);
        irq_in = '0;
        rti_pulse(); rti_pulse();

        // R7, R9, R10: nesting sequence
        reg_write(2'd0, 32'hFFFFFFF8);
        reg_write(2'd1, 32'h00100000);
        reg_write(2'd2, 32'h3);
        irq_in = 32'h00000020;
        @(negedge clk);
        chk("R9 lo take", {31'd0, irq_take}, 32'd1);
        chk("R9 lo id", {27'd0, irq_id}, 32'd5);
        reg_read(2'd2, rd); chk("R9 lo active", rd, 32'h7);
        irq_in = 32'h00100020;
        @(negedge clk);
        chk("R7 preempt take", {31'd0, irq_take}, 32'd1);
        chk("R7 preempt id", {27'd0, irq_id}, 32'd20);
        chk("R7 preempt level", {31'd0, irq_hi}, 32'd1);
        reg_read(2'd2, rd); chk("R9 both active", rd, 32'hF);
        irq_in = 32'h00000020;
        @(negedge clk);
        chk("R7 lo blocked under hi", {31'd0, irq_take}, 32'd0);
        rti_pulse();
        chk("R7 no take during rti", {31'd0, irq_take}, 32'd0);
        reg_read(2'd2, rd); chk("R10 hi cleared first", rd, 32'h7);
        @(negedge clk);
        chk("R7 lo blocked under lo", {31'd0, irq_take}, 32'd0);
        rti_pulse();
        reg_read(2'd2, rd); chk("R10 lo cleared", rd, 32'h3);
        @(negedge clk);
        chk("R10 lo retaken", {31'd0, irq_take}, 32'd1);
        chk("R10 lo retaken id", {27'd0, irq_id}, 32'd5);
        irq_in = '0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule